// File: doc/BRIEF.md
# Fine-Trimmed Precision System Clock

This block keeps a precision system time as a seconds count and a subseconds count, and advances it from a phase accumulator instead of from every clock edge. On every clock a programmable addend is summed into the accumulator. Only the cycles that carry out of the accumulator's top bit move the subsecond count forward by one. Software trims the clock's rate by changing the addend, so the effective tick frequency is the clock frequency times addend / 2^ACC_W.

Software writes a small bank of registers through a plain write port:

- an addend;
- an update seconds value and an update subseconds value, with a direction bit beside the subseconds;
- a target time made of seconds and subseconds.

Two strobes act on the update registers. The initialize strobe loads them straight into the system time. The adjust strobe adds them to the running time, or subtracts them from it, as the direction bit selects. A sticky flag reports that the system time has reached the target, and it stays set until software clears it.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset, every register in the bank is zero. The accumulator, seconds, subseconds and the reached flag are also zero, and `tick_o` is low.
- R2: Each clock, the accumulator takes (accumulator + addend) mod 2^ACC_W. `tick_o` is high in exactly the cycles where that sum carries out of bit ACC_W-1.
- R3: At each clock edge where `tick_o` was high and neither strobe was asserted, the subseconds count increases by one. When the subseconds count is at 2^SUB_W-1, it goes to 0 instead and the seconds count increases by one, mod 2^SEC_W.
- R4: A newly written addend is used from the clock after the write. Writing it does not clear the accumulator.
- R5: `init_i` loads seconds and subseconds from the update registers at the next edge. It takes priority over `adj_i` and over a tick in the same cycle.
- R6: `adj_i` with the direction bit 0 adds the update pair to the time. A carry out of the subseconds sum adds one more second.
- R7: `adj_i` with the direction bit 1 subtracts the update pair from the time. A subseconds borrow takes one more second, and the subseconds wrap mod 2^SUB_W.
- R8: When `adj_i` is asserted without `init_i`, a tick in the same cycle is dropped.
- R9: `reached_o` is set at the edge after a cycle in which seconds > target seconds, or seconds == target seconds and subseconds >= target subseconds. Once set, it stays set.
- R10: `flag_clr_i` clears `reached_o` at the next edge and wins over a set in the same cycle.
- R11: Write select codes: 0 addend, 1 update seconds, 2 update subseconds (low SUB_W bits of the data) with the direction bit at data bit DATA_W-1, 3 target seconds, 4 target subseconds. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | DATA_W | Write data |
| init_i | input | 1 | Initialize strobe |
| adj_i | input | 1 | Signed adjust strobe |
| flag_clr_i | input | 1 | Clear for the reached flag |
| tick_o | output | 1 | Accumulator carry this cycle |
| sec_o | output | SEC_W | System time seconds |
| sub_o | output | SUB_W | System time subseconds |
| reached_o | output | 1 | Sticky target-reached flag |

## Verification
The bench builds the block with an 8-bit accumulator, 6-bit seconds, 5-bit subseconds and a 16-bit data port, so the direction bit sits at data bit 15. With these sizes every addend value from 0 to 255 can be swept in turn without resetting the accumulator. Every adjust offset from 0 to 31 is applied in both directions from low, middle and all-ones subsecond starting points, so each carry and borrow path is taken. The 32-step subsecond range and the 64-second range also let the wraps of both counters and every ordering of time against target occur within a few thousand cycles.

// File: rtl/ptp_fine_pkg.sv
package ptp_fine_pkg;
   typedef enum logic [2:0] {
      SEL_ADDEND = 3'd0,
      SEL_USEC   = 3'd1,
      SEL_USUB   = 3'd2,
      SEL_TSEC   = 3'd3,
      SEL_TSUB   = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_TICK = 2'd1,
      OP_ADJ  = 2'd2,
      OP_LOAD = 2'd3
   } time_op_e;
endpackage

// File: rtl/ptp_fine_regs.sv
module ptp_fine_regs
   import ptp_fine_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 32,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [ACC_W-1:0]  addend_q,
   output logic [SEC_W-1:0]  usec_q,
   output logic [SUB_W-1:0]  usub_q,
   output logic              uneg_q,
   output logic [SEC_W-1:0]  tsec_q,
   output logic [SUB_W-1:0]  tsub_q
);
   localparam int SIGN_BIT = DATA_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addend_q <= '0;
         usec_q   <= '0;
         usub_q   <= '0;
         uneg_q   <= 1'b0;
         tsec_q   <= '0;
         tsub_q   <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_ADDEND: addend_q <= wr_data[ACC_W-1:0];
            SEL_USEC:   usec_q   <= wr_data[SEC_W-1:0];
            SEL_USUB: begin
               usub_q <= wr_data[SUB_W-1:0];
               uneg_q <= wr_data[SIGN_BIT];
            end
            SEL_TSEC:   tsec_q   <= wr_data[SEC_W-1:0];
            SEL_TSUB:   tsub_q   <= wr_data[SUB_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ptp_fine_acc.sv
module ptp_fine_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] addend,
   output logic             carry_o
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum     = {1'b0, acc_q} + {1'b0, addend};
   assign carry_o = sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/ptp_fine_time.sv
module ptp_fine_time
   import ptp_fine_pkg::*;
#(
   parameter int SEC_W = 32,
   parameter int SUB_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             adj,
   input  logic             neg,
   input  logic [SEC_W-1:0] off_sec,
   input  logic [SUB_W-1:0] off_sub,
   output logic [SEC_W-1:0] sec_q,
   output logic [SUB_W-1:0] sub_q
);
   localparam logic [SUB_W-1:0] SUB_MAX = '1;
   localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

   time_op_e         op;
   logic [SUB_W:0]   sub_sum;
   logic [SUB_W:0]   sub_dif;
   logic [SEC_W-1:0] sec_nx;
   logic [SUB_W-1:0] sub_nx;

   assign sub_sum = {1'b0, sub_q} + {1'b0, off_sub};
   assign sub_dif = {1'b0, sub_q} - {1'b0, off_sub};

   always_comb begin
      if (load)      op = OP_LOAD;
      else if (adj)  op = OP_ADJ;
      else if (tick) op = OP_TICK;
      else           op = OP_HOLD;
   end

   always_comb begin
      sec_nx = sec_q;
      sub_nx = sub_q;
      case (op)
         OP_LOAD: begin
            sec_nx = off_sec;
            sub_nx = off_sub;
         end
         OP_ADJ: begin
            if (neg) begin
               sub_nx = sub_dif[SUB_W-1:0];
               sec_nx = sec_q - off_sec - SEC_W'(sub_dif[SUB_W]);
            end else begin
               sub_nx = sub_sum[SUB_W-1:0];
               sec_nx = sec_q + off_sec + SEC_W'(sub_sum[SUB_W]);
            end
         end
         OP_TICK: begin
            if (sub_q == SUB_MAX) begin
               sub_nx = '0;
               sec_nx = sec_q + SEC_ONE;
            end else begin
               sub_nx = sub_q + SUB_W'(1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         sub_q <= '0;
      end else begin
         sec_q <= sec_nx;
         sub_q <= sub_nx;
      end
   end
endmodule

// File: rtl/ptp_fine_cmp.sv
module ptp_fine_cmp #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] sec,
   input  logic [SUB_W-1:0] sub,
   input  logic [SEC_W-1:0] tsec,
   input  logic [SUB_W-1:0] tsub,
   input  logic             clr,
   output logic             flag_q
);
   logic hit;

   assign hit = (sec > tsec) || ((sec == tsec) && (sub >= tsub));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (clr) flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
   end
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 32,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              init_i,
   input  logic              adj_i,
   input  logic              flag_clr_i,
   output logic              tick_o,
   output logic [SEC_W-1:0]  sec_o,
   output logic [SUB_W-1:0]  sub_o,
   output logic              reached_o
);
   generate
      if (ACC_W > DATA_W || SEC_W > DATA_W || SUB_W >= DATA_W)
         $error("ptp_fine_clock: a field is wider than the data port allows");
      if (ACC_W < 2 || SUB_W < 2 || SEC_W < 2)
         $error("ptp_fine_clock: widths must be at least 2");
   endgenerate

   logic [ACC_W-1:0] addend_q;
   logic [SEC_W-1:0] usec_q;
   logic [SUB_W-1:0] usub_q;
   logic             uneg_q;
   logic [SEC_W-1:0] tsec_q;
   logic [SUB_W-1:0] tsub_q;

   ptp_fine_regs #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
      .addend_q(addend_q), .usec_q(usec_q), .usub_q(usub_q), .uneg_q(uneg_q),
      .tsec_q(tsec_q), .tsub_q(tsub_q)
   );

   ptp_fine_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .addend(addend_q), .carry_o(tick_o)
   );

   ptp_fine_time #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick_o), .load(init_i), .adj(adj_i), .neg(uneg_q),
      .off_sec(usec_q), .off_sub(usub_q), .sec_q(sec_o), .sub_q(sub_o)
   );

   ptp_fine_cmp #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .sec(sec_o), .sub(sub_o), .tsec(tsec_q), .tsub(tsub_q),
      .clr(flag_clr_i), .flag_q(reached_o)
   );
endmodule

// File: rtl/ptp_fine_clock_chk.sv
module ptp_fine_clock_chk #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_i,
   input logic             adj_i,
   input logic             flag_clr_i,
   input logic             tick_o,
   input logic [SEC_W-1:0] sec_o,
   input logic [SUB_W-1:0] sub_o,
   input logic             reached_o,
   input logic [SEC_W-1:0] usec_q,
   input logic [SUB_W-1:0] usub_q
);
   localparam logic [SUB_W-1:0] SUB_MAX = '1;

   // R3: a plain tick below the top step moves the subseconds forward by one
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !init_i && !adj_i && sub_o != SUB_MAX)
      |=> (sub_o == SUB_W'($past(sub_o) + SUB_W'(1))) && $stable(sec_o));

   // R3: a tick at the top step wraps the subseconds and carries into seconds
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !init_i && !adj_i && sub_o == SUB_MAX)
      |=> (sub_o == '0) && (sec_o == SEC_W'($past(sec_o) + SEC_W'(1))));

   // R2: without a carry or a strobe the time holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_o && !init_i && !adj_i) |=> $stable(sec_o) && $stable(sub_o));

   // R5: initialize loads the update pair
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (sec_o == $past(usec_q)) && (sub_o == $past(usub_q)));

   // R9: the flag is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (reached_o && !flag_clr_i) |=> reached_o);

   // R10: a clear always wins
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_i |=> !reached_o);
endmodule

bind ptp_fine_clock ptp_fine_clock_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .adj_i(adj_i), .flag_clr_i(flag_clr_i),
   .tick_o(tick_o), .sec_o(sec_o), .sub_o(sub_o), .reached_o(reached_o),
   .usec_q(usec_q), .usub_q(usub_q)
);

// File: tb/ptp_fine_clock_tb.sv
module ptp_fine_clock_tb;
   localparam int DATA_W = 16;
   localparam int ACC_W  = 8;
   localparam int SEC_W  = 6;
   localparam int SUB_W  = 5;
   localparam int AM = (1 << ACC_W) - 1;
   localparam int SM = (1 << SEC_W) - 1;
   localparam int UM = (1 << SUB_W) - 1;
   localparam int NEG = 1 << (DATA_W - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [2:0]        wr_sel_i = '0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic              init_i = 1'b0;
   logic              adj_i = 1'b0;
   logic              flag_clr_i = 1'b0;
   logic              tick_o;
   logic [SEC_W-1:0]  sec_o;
   logic [SUB_W-1:0]  sub_o;
   logic              reached_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int m_add = 0, m_usec = 0, m_usub = 0, m_neg = 0, m_tsec = 0, m_tsub = 0;
   int m_acc = 0, m_sec = 0, m_sub = 0, m_flag = 0;

   always #5 clk = ~clk;

   ptp_fine_clock #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .init_i(init_i), .adj_i(adj_i), .flag_clr_i(flag_clr_i), .tick_o(tick_o),
      .sec_o(sec_o), .sub_o(sub_o), .reached_o(reached_o)
   );

   function automatic int exp_tick();
      return ((m_acc + m_add) >> ACC_W) & 1;
   endfunction

   task automatic model_step();
      int s, u, t, b, hit, tk, d;
      tk  = exp_tick();
      hit = (m_sec > m_tsec || (m_sec == m_tsec && m_sub >= m_tsub)) ? 1 : 0;
      s = m_sec; u = m_sub;
      if (init_i) begin
         s = m_usec; u = m_usub;
      end else if (adj_i) begin
         if (m_neg == 0) begin
            t = m_sub + m_usub;
            u = t & UM;
            s = (m_sec + m_usec + (t >> SUB_W)) & SM;
         end else begin
            t = m_sub - m_usub;
            b = (t < 0) ? 1 : 0;
            u = t & UM;
            s = (m_sec - m_usec - b) & SM;
         end
      end else if (tk == 1) begin
         if (m_sub == UM) begin
            u = 0; s = (m_sec + 1) & SM;
         end else u = m_sub + 1;
      end
      m_acc = (m_acc + m_add) & AM;
      m_sec = s; m_sub = u;
      m_flag = flag_clr_i ? 0 : (m_flag | hit);
      if (wr_en_i) begin
         d = int'(wr_data_i);
         case (wr_sel_i)
            3'd0: m_add = d & AM;
            3'd1: m_usec = d & SM;
            3'd2: begin m_usub = d & UM; m_neg = (d >> (DATA_W - 1)) & 1; end
            3'd3: m_tsec = d & SM;
            3'd4: m_tsub = d & UM;
            default: ;
         endcase
      end
   endtask

   task automatic compare(input string req);
      total++;
      if (int'(sec_o) != m_sec || int'(sub_o) != m_sub ||
          int'(reached_o) != m_flag || int'(tick_o) != exp_tick()) begin
         bad++;
         $display("FAIL %s: got sec=%0d sub=%0d flag=%0d tick=%0d, want sec=%0d sub=%0d flag=%0d tick=%0d",
                  req, sec_o, sub_o, reached_o, tick_o, m_sec, m_sub, m_flag, exp_tick());
      end
   endtask

   task automatic cyc(input string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(req);
   endtask

   task automatic run(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(req);
   endtask

   task automatic wr(input int sel, input int data, input string req);
      wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = DATA_W'(data);
      cyc(req);
      wr_en_i = 1'b0;
   endtask

   task automatic strobe(input bit ini, input bit adj, input bit clr, input string req);
      init_i = ini; adj_i = adj; flag_clr_i = clr;
      cyc(req);
      init_i = 1'b0; adj_i = 1'b0; flag_clr_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      run(3, "R1");

      // R11 select codes, R2 carries, R3 increments and wrap
      wr(0, 'h35, "R11");
      run(80, "R2");
      wr(0, 'hF0, "R3");
      run(120, "R3");

      // R4: sweep every addend without touching the accumulator
      for (int a = 0; a <= AM; a++) begin
         wr(0, a, "R4");
         run(6, "R4");
      end

      // R3: wrap at top subsecond with a fast addend
      wr(1, 10, "R5"); wr(2, UM, "R5");
      strobe(1'b1, 1'b0, 1'b0, "R5");
      wr(0, 'hFF, "R3");
      run(6, "R3");

      // R6, R7: all offsets both directions from several starting points
      wr(0, 'h40, "R8");
      for (int ng = 0; ng < 2; ng++) begin
         for (int si = 0; si < 3; si++) begin
            for (int off = 0; off <= UM; off++) begin
               wr(1, 20 + si, "R5");
               wr(2, (si == 0) ? 0 : (si == 1) ? 9 : UM, "R5");
               strobe(1'b1, 1'b0, 1'b0, "R5");
               wr(1, 3 + off, ng ? "R7" : "R6");
               wr(2, off | (ng ? NEG : 0), ng ? "R7" : "R6");
               strobe(1'b0, 1'b1, 1'b0, ng ? "R7" : "R6");
               run(1, ng ? "R7" : "R6");
            end
         end
      end

      // R5 and R8: strobe collisions with ticks
      wr(0, 'hFF, "R8");
      wr(1, 7, "R5"); wr(2, 4, "R5");
      for (int k = 0; k < 8; k++) begin
         strobe(1'b1, 1'b1, 1'b0, "R5");
         strobe(1'b0, 1'b1, 1'b0, "R8");
         run(2, "R8");
      end

      // R9, R10: target reached, sticky and cleared
      wr(1, 2, "R9"); wr(2, 28, "R9");
      strobe(1'b1, 1'b0, 1'b0, "R9");
      wr(3, 3, "R9"); wr(4, 1, "R9");
      run(12, "R9");
      strobe(1'b0, 1'b0, 1'b1, "R10");
      run(3, "R10");
      wr(3, 40, "R10");
      strobe(1'b0, 1'b0, 1'b1, "R10");
      run(20, "R10");
      wr(0, 'h01, "R9");
      wr(3, 5, "R9"); wr(4, 0, "R9");
      run(40, "R9");
      strobe(1'b1, 1'b1, 1'b1, "R10");

      // R11: unused codes change nothing
      for (int c = 5; c < 8; c++) begin
         wr(c, 'hFFFF, "R11");
         run(8, "R11");
      end
      strobe(1'b1, 1'b0, 1'b0, "R11");
      strobe(1'b0, 1'b1, 1'b0, "R11");
      run(4, "R11");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got running, want finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule